// File: doc/BRIEF.md
# Serial-Loaded Converter Code Register

This block is the digital front end of a serial-input voltage DAC. A host shifts a code word into a shift register one bit at a time, most significant bit first. It then strobes a load line, which copies the word into the holding register that drives the converter. A clear line forces the holding register to zero at any time. The analog section is not part of this block.

All five host lines are asynchronous to the block. Each one passes through a flop synchronizer clocked by a fast system clock. The shift register moves on the rising edge of a combined shift clock, formed as the OR of the serial clock and the active-low select. As a result, releasing select while the serial clock is low adds one extra shift. The holding register follows the shift register for as long as load is low, and keeps its value once load returns high.

Top module: `serial_dac_frontend`

## Requirements
- R1: The register width is WIDTH bits (12 by default) in natural binary. The first bit shifted in ends up as the most significant bit of `dac_code`, so after WIDTH shifts and a load, `dac_code` equals the word that was sent.
- R2: While `sel_n` is low, each rising edge of `ser_clk` shifts the register left by one bit and enters `ser_din` at bit 0.
- R3: While `sel_n` is high, toggling `ser_clk` leaves the shift register unchanged.
- R4: A rising edge of `sel_n` while `ser_clk` is low causes exactly one extra shift, taking in the current `ser_din`. A rising edge of `sel_n` while `ser_clk` is high causes no shift.
- R5: While `load_n` is low and `clear_n` is high, `dac_code` follows the shift register contents.
- R6: While `load_n` and `clear_n` are both high, `dac_code` holds its value, even while a new word is being shifted in.
- R7: While `clear_n` is low, `dac_code` is zero. After `clear_n` rises, `dac_code` stays zero until the next time `load_n` goes low.
- R8: When `clear_n` and `load_n` are both low, the clear wins and `dac_code` is zero.
- R9: `load_n` and `clear_n` never change the shift register contents.
- R10: After reset, `dac_code` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the host lines |
| rst_n | input | 1 | Active-low reset of the block |
| ser_clk | input | 1 | Serial shift clock from the host |
| ser_din | input | 1 | Serial data, most significant bit first |
| sel_n | input | 1 | Active-low select that gates shifting |
| load_n | input | 1 | Active-low, level-sensitive transfer to the holding register |
| clear_n | input | 1 | Active-low clear of the holding register |
| dac_code | output | WIDTH | Code driving the converter |

## Verification
The bench builds the block with its default parameters: WIDTH = 12 and SYNC_STAGES = 2. With a 12-bit width, the all-ones word 0xFFF, the all-zeros word and alternating patterns all fit in short runs. An extra shift caused by releasing select has an exactly predictable result: the previous word moved left by one place, with the new bit entering at the bottom. Each host line is held for six system clocks, which is longer than the two-flop synchronizer plus the edge detector and the two register stages. Because of this, every expected value can be computed from the requirements alone.

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend #(
  parameter int WIDTH       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_din,
  input  logic             sel_n,
  input  logic             load_n,
  input  logic             clear_n,
  output logic [WIDTH-1:0] dac_code
);

  localparam int LINES = 5;
  localparam logic [LINES-1:0] IDLE_LVL = 5'b01110;

  logic [LINES-1:0] sync_q [SYNC_STAGES];
  logic [LINES-1:0] lines;
  logic             shclk_q;
  logic [WIDTH-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= IDLE_LVL;
    end else begin
      sync_q[0] <= {ser_din, clear_n, load_n, sel_n, ser_clk};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign lines = sync_q[SYNC_STAGES-1];

  wire din_s  = lines[4];
  wire clr_s  = lines[3];
  wire ld_s   = lines[2];
  wire sel_s  = lines[1];
  wire clk_s  = lines[0];
  wire shclk  = clk_s | sel_s;
  wire rise   = shclk & ~shclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shclk_q  <= 1'b1;
      shreg    <= '0;
      dac_code <= '0;
    end else begin
      shclk_q <= shclk;
      if (rise) shreg <= {shreg[WIDTH-2:0], din_s};
      if (!clr_s)     dac_code <= '0;
      else if (!ld_s) dac_code <= shreg;
    end
  end

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> shreg[0] == $past(din_s)); // R2
  AST_SEL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s && $past(sel_s)) |=> $stable(shreg)); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> dac_code == '0); // R7
  AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_s && !ld_s) |=> dac_code == $past(shreg)); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_s && ld_s) |=> $stable(dac_code)); // R6

endmodule

// File: tb/tb_serial_dac_frontend.sv
module tb_serial_dac_frontend;
  localparam int W = 12;
  localparam int HOLD = 6;

  logic clk = 0, rst_n = 0;
  logic ser_clk = 1, ser_din = 0, sel_n = 1, load_n = 1, clear_n = 1;
  logic [W-1:0] dac_code;
  int checks = 0, errors = 0;

  serial_dac_frontend #(.WIDTH(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .sel_n(sel_n), .load_n(load_n), .clear_n(clear_n), .dac_code(dac_code));

  always #4 clk = ~clk;

  task automatic settle();
    repeat (HOLD) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %03h expected %03h", req, got, exp);
    end
  endtask

  task automatic shift_word(logic [W-1:0] w);
    sel_n = 0; settle();
    for (int i = W - 1; i >= 0; i--) begin
      ser_clk = 0; ser_din = w[i]; settle();
      ser_clk = 1; settle();
    end
    sel_n = 1; settle();
  endtask

  task automatic pulse_load();
    load_n = 0; settle();
    load_n = 1; settle();
  endtask

  task automatic t_word(logic [W-1:0] w);
    shift_word(w);
    pulse_load();
    check("R1 R2 word", dac_code, w);
  endtask

  task automatic t_sel_high(logic [W-1:0] prev);
    ser_din = 1;
    for (int i = 0; i < 5; i++) begin
      ser_clk = 0; settle();
      ser_clk = 1; settle();
    end
    pulse_load();
    check("R3 clk ignored", dac_code, prev);
  endtask

  task automatic t_false_shift();
    shift_word(12'h123);
    sel_n = 0; settle();
    ser_clk = 0; ser_din = 1; settle();
    sel_n = 1; settle();
    ser_clk = 1; settle();
    pulse_load();
    check("R4 extra shift", dac_code, 12'h247);
  endtask

  task automatic t_transparent_hold();
    shift_word(12'h5A3);
    load_n = 0; settle();
    check("R5 transparent", dac_code, 12'h5A3);
    load_n = 1; settle();
    shift_word(12'h0F0);
    check("R6 hold during preload", dac_code, 12'h5A3);
    pulse_load();
    check("R9 preload kept", dac_code, 12'h0F0);
  endtask

  task automatic t_clear();
    clear_n = 0; settle();
    check("R7 clear", dac_code, 12'h000);
    clear_n = 1; settle();
    check("R7 stays zero", dac_code, 12'h000);
    pulse_load();
    check("R9 clear kept shift reg", dac_code, 12'h0F0);
  endtask

  task automatic t_priority();
    shift_word(12'hC3C);
    load_n = 0; clear_n = 0; settle();
    check("R8 clear wins", dac_code, 12'h000);
    clear_n = 1; settle();
    check("R8 load after clear", dac_code, 12'hC3C);
    load_n = 1; settle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset", dac_code, 12'h000);
    rst_n = 1; settle();
    check("R10 after reset", dac_code, 12'h000);
    t_word(12'hA5C);
    t_word(12'hFFF);
    t_word(12'h000);
    t_word(12'h3F1);
    t_sel_high(12'h3F1);
    t_false_shift();
    t_transparent_hold();
    t_clear();
    t_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule